// File: doc/BRIEF.md
# Clock Source Fallback Controller

This block chooses the source of the main output clock for an audio receiver. While the receiver PLL holds lock, the recovered clock drives the output. When lock drops, the block starts timing the crystal oscillator's start-up. It counts millisecond ticks, and the tick input comes from the PLL's own free-running clock domain. Once the programmed settling time has passed with the receiver still unlocked, the block moves the output to the crystal. It moves back to the recovered clock as soon as lock returns. Software can also force the source to the receiver, to the crystal or to one of three auxiliary inputs. The automatic behaviour applies only while the source command is "auto".

Next to the source select, the block drives a clock-status flag. Each clock-condition event raises the flag. The flag drops after a programmable number of preamble strobes, the same count that governs release of the error flag. In the basic mode, only changes of the lock state count as events. In the extended mode, the following also count: a source command to the crystal or to an auxiliary input, an automatic switch between receiver and crystal, and a main-port sample-rate change. A polarity input chooses whether the flag is active high or active low.

The block has no data stream. Every pin is a plain control or status level, or a single-cycle strobe, and none of them carries back-pressure.

Top module: `clk_fallback_ctrl`

## Requirements
- R1: The settling time is WAIT_BASE shifted left by `wait_sel_i` millisecond ticks: 1, 2, 4 or 8 times WAIT_BASE for codes 0 to 3. With the default WAIT_BASE of 25 this gives 25, 50, 100 or 200 ms.
- R2: In auto mode, `main_src_o` changes from receiver (code 0) to crystal (code 1) in the cycle after the tick that completes the settling time. That tick must come while `lock_i` has stayed low the whole time. At no other moment does the output change from receiver to crystal.
- R3: If `lock_i` returns high before the settling time has passed, the tick count goes back to zero and the source stays on the receiver. The next loss of lock needs the full settling time again.
- R4: In auto mode, when `lock_i` is high, the source is the receiver from the next cycle on. This holds even after a fallback to the crystal.
- R5: A write (`src_wr_i`) of `src_cmd_i` selects the mode from the next cycle on, with this encoding: 0 = auto, 1 = receiver, 2 = crystal, 3/4/5 = auxiliary 0/1/2. In the forced modes, `main_src_o` is 0 for the receiver, 1 for the crystal, and 2/3/4 for auxiliary 0/1/2. Command codes 6 and 7 are ignored.
- R6: `clk_status_o` equals `status_pol_i` while the flag is active and its inverse while the flag is idle. The default polarity 0 is therefore active low. After reset the flag is idle.
- R7: With `ext_mode_i` low, only a change of `lock_i` is an event. Source writes, automatic switches and `rate_chg_i` have no effect on the flag.
- R8: With `ext_mode_i` high, each of the following is also an event: a write of command codes 2 to 5, a change of source caused by the automatic fallback or its return while in auto mode, and a `rate_chg_i` strobe.
- R9: A write of command 0 (auto) or command 1 (receiver) is never an event.
- R10: An event makes the flag active from the next cycle. The flag goes idle after N further `preamble_i` strobes, where N is REL_BASE, REL_BASE/4, REL_BASE/8 or REL_BASE/16 for `rel_sel_i` codes 0 to 3; the defaults are 48/12/6/3. A new event reloads N. When an event and a strobe arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Receiver PLL locked |
| ms_tick_i | input | 1 | One-cycle strobe per millisecond of the free-running PLL clock |
| preamble_i | input | 1 | One-cycle strobe per block-start preamble |
| wait_sel_i | input | 2 | Crystal settling time select |
| rel_sel_i | input | 2 | Flag release count select |
| status_pol_i | input | 1 | Flag polarity, 1 = active high |
| ext_mode_i | input | 1 | 1 = extended event set |
| src_wr_i | input | 1 | Source command write strobe |
| src_cmd_i | input | 3 | Source command code |
| rate_chg_i | input | 1 | Main-port sample-rate change strobe |
| main_src_o | output | 3 | Selected main clock source |
| clk_status_o | output | 1 | Clock-status flag |

## Verification
The bench builds the block with WAIT_BASE = 3 and REL_BASE = 16. The settling times then become 3, 6, 12 and 24 ticks, and the release counts become 16, 4, 2 and 1 strobes. With these values every wait code and every release code can be run to completion in a few hundred cycles. The short windows also make relock-before-expiry, reload-on-new-event and event-beats-strobe easy to place precisely, and the largest settings are covered as well as the smallest.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [2:0] {
    SRC_RCV  = 3'd0,
    SRC_XTAL = 3'd1,
    SRC_AUX0 = 3'd2,
    SRC_AUX1 = 3'd3,
    SRC_AUX2 = 3'd4
  } src_e;

  typedef enum logic [2:0] {
    CMD_AUTO = 3'd0,
    CMD_RCV  = 3'd1,
    CMD_XTAL = 3'd2,
    CMD_AUX0 = 3'd3,
    CMD_AUX1 = 3'd4,
    CMD_AUX2 = 3'd5
  } cmd_e;

  localparam logic [2:0] CMD_LAST = 3'd5;
endpackage

// File: rtl/cfs_wait_timer.sv
module cfs_wait_timer #(
  parameter int WAIT_BASE = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       ms_tick_i,
  input  logic [1:0] wait_sel_i,
  output logic       fb_o,
  output logic       fb_set_o,
  output logic       fb_clr_o
);
  localparam int MAXLIM = WAIT_BASE * 8;
  localparam int CW     = $clog2(MAXLIM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          hit;

  always_comb begin
    limit    = CW'(WAIT_BASE) << wait_sel_i;
    hit      = (cnt >= limit - CW'(1));
    fb_set_o = !lock_i && ms_tick_i && !fb_o && hit;
    fb_clr_o = lock_i && fb_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fb_o <= 1'b0;
    end else if (lock_i) begin
      cnt  <= '0;
      fb_o <= 1'b0;
    end else if (ms_tick_i && !fb_o) begin
      if (hit) begin
        fb_o <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cfs_src_mode.sv
module cfs_src_mode
  import cfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] cmd_i,
  input  logic       fb_i,
  output logic       mode_auto_o,
  output logic       upd_evt_o,
  output logic [2:0] src_o
);
  logic [2:0] mode;
  logic       legal;

  always_comb begin
    legal       = (cmd_i <= CMD_LAST);
    upd_evt_o   = wr_i && legal && (cmd_i >= CMD_XTAL);
    mode_auto_o = (mode == CMD_AUTO);
    if (mode == CMD_AUTO) src_o = fb_i ? SRC_XTAL : SRC_RCV;
    else                  src_o = mode - 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode <= CMD_AUTO;
    else if (wr_i && legal)  mode <= cmd_i;
  end
endmodule

// File: rtl/cfs_status_hold.sv
module cfs_status_hold #(
  parameter int REL_BASE = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       event_i,
  input  logic       preamble_i,
  input  logic [1:0] rel_sel_i,
  input  logic       pol_i,
  output logic       status_o
);
  localparam int RW = $clog2(REL_BASE + 1);

  logic [RW-1:0] rel_cnt;
  logic [RW-1:0] reload;

  always_comb begin
    case (rel_sel_i)
      2'd0:    reload = RW'(REL_BASE);
      2'd1:    reload = RW'(REL_BASE / 4);
      2'd2:    reload = RW'(REL_BASE / 8);
      default: reload = RW'(REL_BASE / 16);
    endcase
    status_o = (rel_cnt != '0) ? pol_i : !pol_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rel_cnt <= '0;
    else if (event_i)                     rel_cnt <= reload;
    else if (preamble_i && rel_cnt != '0) rel_cnt <= rel_cnt - RW'(1);
  end
endmodule

// File: rtl/clk_fallback_ctrl.sv
module clk_fallback_ctrl #(
  parameter int WAIT_BASE = 25,
  parameter int REL_BASE  = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       ms_tick_i,
  input  logic       preamble_i,
  input  logic [1:0] wait_sel_i,
  input  logic [1:0] rel_sel_i,
  input  logic       status_pol_i,
  input  logic       ext_mode_i,
  input  logic       src_wr_i,
  input  logic [2:0] src_cmd_i,
  input  logic       rate_chg_i,
  output logic [2:0] main_src_o,
  output logic       clk_status_o
);
  logic lock_q;
  logic fb, fb_set, fb_clr;
  logic mode_auto, upd_evt;
  logic evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_i;
  end

  cfs_wait_timer #(.WAIT_BASE(WAIT_BASE)) u_timer (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .ms_tick_i(ms_tick_i),
    .wait_sel_i(wait_sel_i), .fb_o(fb), .fb_set_o(fb_set), .fb_clr_o(fb_clr)
  );

  cfs_src_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr_i(src_wr_i), .cmd_i(src_cmd_i), .fb_i(fb),
    .mode_auto_o(mode_auto), .upd_evt_o(upd_evt), .src_o(main_src_o)
  );

  always_comb begin
    evt = (lock_i != lock_q);
    if (ext_mode_i)
      evt = evt || upd_evt || rate_chg_i || (mode_auto && (fb_set || fb_clr));
  end

  cfs_status_hold #(.REL_BASE(REL_BASE)) u_hold (
    .clk(clk), .rst_n(rst_n), .event_i(evt), .preamble_i(preamble_i),
    .rel_sel_i(rel_sel_i), .pol_i(status_pol_i), .status_o(clk_status_o)
  );
endmodule

// File: rtl/clk_fallback_ctrl_sva.sv
module clk_fallback_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_i,
  input logic       src_wr_i,
  input logic       status_pol_i,
  input logic [2:0] main_src_o,
  input logic       clk_status_o,
  input logic       mode_auto,
  input logic       fb
);
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    main_src_o <= 3'd4);  // R5

  AST_FB_AFTER_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb) |-> !$past(lock_i));  // R2

  AST_FB_DROPS_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> !fb);  // R3

  AST_RELOCK_RCV: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && mode_auto && !src_wr_i) |=> (main_src_o == 3'd0));  // R4

  AST_LOCK_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_i) |=> (clk_status_o == status_pol_i));  // R7
endmodule

bind clk_fallback_ctrl clk_fallback_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .src_wr_i(src_wr_i),
  .status_pol_i(status_pol_i), .main_src_o(main_src_o),
  .clk_status_o(clk_status_o), .mode_auto(mode_auto), .fb(fb)
);

// File: tb/clk_fallback_ctrl_tb_top.sv
`timescale 1ns/100ps
module clk_fallback_ctrl_tb_top;
  localparam int WB = 3;
  localparam int RB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 0, tick = 0, pre = 0, pol = 0, ext = 0, wr = 0, rate = 0;
  logic [1:0] wsel = 0, rsel = 0;
  logic [2:0] cmd = 0;
  logic [2:0] src;
  logic       st;

  int total = 0, bad = 0;
  string cur_req = "R6";
  bit done = 0;

  int m_lockq, m_cnt, m_fb, m_mode, m_rel;

  always #2.5 clk = ~clk;

  clk_fallback_ctrl #(.WAIT_BASE(WB), .REL_BASE(RB)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_i(lock), .ms_tick_i(tick), .preamble_i(pre),
    .wait_sel_i(wsel), .rel_sel_i(rsel), .status_pol_i(pol), .ext_mode_i(ext),
    .src_wr_i(wr), .src_cmd_i(cmd), .rate_chg_i(rate),
    .main_src_o(src), .clk_status_o(st)
  );

  // behavioural reference, evaluated on the inputs present at each edge
  always @(posedge clk) begin
    int ev, fbn, lim, n;
    if (!rst_n) begin
      m_lockq = 0; m_cnt = 0; m_fb = 0; m_mode = 0; m_rel = 0;
    end else begin
      ev  = (lock != m_lockq);
      fbn = m_fb;
      lim = WB * (1 << wsel);
      if (lock) begin m_cnt = 0; fbn = 0; end
      else if (tick && !m_fb) begin
        if (m_cnt >= lim - 1) begin fbn = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      if (ext) begin
        if (wr && cmd >= 2 && cmd <= 5) ev = 1;
        if (rate) ev = 1;
        if (m_mode == 0 && fbn != m_fb) ev = 1;
      end
      n = (rsel == 0) ? RB : (rsel == 1) ? RB / 4 : (rsel == 2) ? RB / 8 : RB / 16;
      if (ev) m_rel = n;
      else if (pre && m_rel > 0) m_rel = m_rel - 1;
      if (wr && cmd <= 5) m_mode = cmd;
      m_fb = fbn;
      m_lockq = lock;
    end
  end

  function automatic int exp_src();
    if (m_mode == 0) return m_fb ? 1 : 0;
    return m_mode - 1;
  endfunction

  always @(negedge clk) begin
    int es, et;
    if (!done) begin
      es = exp_src();
      et = (m_rel != 0) ? pol : !pol;
      total++;
      if (src !== 3'(es)) begin
        bad++;
        $display("FAIL %s main_src act=%0d exp=%0d t=%0t", cur_req, src, es, $time);
      end
      total++;
      if (st !== 1'(et)) begin
        bad++;
        $display("FAIL %s clk_status act=%0d exp=%0d t=%0t", cur_req, st, et, $time);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk); #1;
      tick = 0; pre = 0; wr = 0; rate = 0;
    end
  endtask
  task automatic ticks(int n);
    repeat (n) begin tick = 1; cyc(); end
  endtask
  task automatic pres(int n);
    repeat (n) begin pre = 1; cyc(); end
  endtask
  task automatic write(logic [2:0] c);
    cmd = c; wr = 1; cyc();
  endtask

  initial begin
    cur_req = "R6"; cyc(3); rst_n = 1; cyc(2);
    cur_req = "R10"; lock = 1; cyc(); pres(15); cyc(2); pres(1); cyc(2);
    rsel = 3; lock = 0; cyc(); pres(1); cyc();
    cur_req = "R1"; ticks(2); cyc(2); ticks(1); cyc(2);
    cur_req = "R4"; lock = 1; cyc(3); pres(1);
    cur_req = "R3"; lock = 0; ticks(2); lock = 1; cyc(); lock = 0; ticks(2); cyc(); ticks(1); cyc(2);
    lock = 1; cyc(); pres(1);
    cur_req = "R1"; wsel = 3; lock = 0; ticks(23); cyc(2); ticks(1); cyc(2);
    wsel = 1; lock = 1; cyc(); pres(1); lock = 0; ticks(5); cyc(); ticks(1); cyc(); pres(1);
    cur_req = "R7"; write(2); cyc(); rate = 1; cyc(); write(0); pres(1); cyc();
    lock = 1; cyc(); pres(1);
    cur_req = "R8"; ext = 1; write(2); cyc(2); pres(1);
    cur_req = "R5"; write(4); cyc(); pres(1); write(5); pres(1); write(7); cyc(); write(3); pres(1);
    cur_req = "R9"; write(1); cyc(2); write(0); cyc(2);
    cur_req = "R8"; rate = 1; cyc(); pres(1);
    wsel = 0; lock = 0; cyc(); pres(1); ticks(3); cyc(2); pres(1);
    lock = 1; cyc(); pres(1);
    cur_req = "R6"; pol = 1; cyc(2); rate = 1; cyc(2); pres(1); cyc(2);
    cur_req = "R10"; rsel = 1; rate = 1; cyc(); pres(2); rate = 1; cyc(); pres(3); cyc(); pres(1);
    rate = 1; pre = 1; cyc(); cyc(); pres(4); cyc(2);
    rsel = 2; rate = 1; cyc(); pres(2); cyc(2);
    cur_req = "R7"; ext = 0; rate = 1; cyc(2); write(2); cyc(2); write(0); cyc(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule